// File: doc/BRIEF.md
# Byte-Lane Register File Core

This block is a flip-flop register file that is independent of any particular bus. A protocol adapter drives it with a write port and a separate read port. The write port takes a word address, a data word, a byte-enable vector with one bit per data byte, and a write strobe. The read port takes a word address and a read strobe, and returns a formatted data word together with a success flag. The write port also reports, in the same cycle, whether the write landed on a writable location.

The map has two kinds of location. Freestanding word registers sit at fixed offsets, and each one carries three masks: the bits it implements, the bits it protects from writes, and its reset value. A register array occupies a contiguous window given by a base offset, a frame size in words and a frame count, and its words are indexed relative to that base. With the default parameters:
- registers live at offsets 0 to 7 and 12;
- offset 7 is entirely read-only;
- offset 12 protects its low byte;
- a 128-word array fills offsets 128 to 255.

Both ports are plain strobes with no ready signal. The core accepts every strobe in the cycle it is presented, so there is never back-pressure. The upstream adapter can therefore turn `wr_ok` and `rd_ok` directly into its own acknowledge or error response.

Top module: `regfile_core`

## Requirements
- R1: The reset is synchronous and active high. It loads every register with its reset value, masked to the implemented bits. Default values: offset 1 = 0x0BADF00D, offset 3 = 0x00AA0055, offset 4 = 0x11110000, offset 7 = 0x5A5A0001, offset 12 = 0x000000C3, all other registers and all array words = 0.
- R2: Bit k of `wr_be` enables byte lane `wr_data[8k+7:8k]`. In a disabled lane, stored bits keep their previous value. With `wr_be` all zero, nothing changes.
- R3: Read-only bits never change on a write, even when their lane is enabled. Offset 7 is read-only in all 32 bits. Offset 12 is read-only in bits [7:0].
- R4: Bit positions that a register does not implement always read as 0. These are bits [31:16] of offset 2, bits [31:24] and [15:8] of offset 3, and bits [31:16] of offset 12.
- R5: `wr_ok` is combinational and valid in the same cycle as `wr_en`. It is 1 only when the offset selects an array word or a register that has at least one writable bit. With the defaults, offset 7 reports 0. A write that reports 0 changes no state.
- R6: `rd_ok` is combinational and valid in the same cycle as `rd_en`. It is 1 only when the offset selects a mapped location. When `rd_ok` is 0, `rd_data` is 0.
- R7: Offsets from ARR_BASE to ARR_BASE + ARR_FRAME*ARR_COUNT - 1 (default 128 to 255) select array word (offset - ARR_BASE).
- R8: Only the low MAP_W bits (default 8) of the 16-bit bus word address form the register offset. For example, address 0x0105 reaches offset 5.
- R9: A write takes effect at the rising edge where `wr_en` is high. A read in that same cycle returns the old value, and a read in the next cycle returns the new value.
- R10: With the defaults, offsets 8 to 11 and 13 to 127 are unmapped. Both ports report failure for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | BUS_AW (16) | Bus word address for the write |
| wr_be | input | DW/8 (4) | Byte-lane enables for the write |
| wr_data | input | DW (32) | Write data |
| wr_ok | output | 1 | Write hit a writable location (same cycle) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | BUS_AW (16) | Bus word address for the read |
| rd_data | output | DW (32) | Read data, zero on failure |
| rd_ok | output | 1 | Read hit a mapped location (same cycle) |

## Verification
The bench targets these corner cases:
- **Partial byte enables.** A design that ignored `wr_be` would overwrite the neighbouring bytes.
- **All-ones writes to the protected low byte of offset 12 and to read-only offset 7.** A design that skipped the read-only mask would corrupt them.
- **Writes of all ones to partially implemented registers.** A design that stored every bit would read back nonzero upper bits.
- **The array edges (127, 128, 255) and aliased bus addresses.** These catch off-by-one decoding and the use of too many address bits.
- **A read and a write to the same offset in one cycle.** This exposes a read path that wrongly forwards the write data.
- **Unmapped offsets.** A design that acknowledged them, or leaked stale data on failure, would be caught here.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_FREE  = 2'd1,
    SRC_ARRAY = 2'd2
  } rfc_src_e;

  localparam int DEF_DW     = 32;
  localparam int DEF_MAP_W  = 8;
  localparam int DEF_N_FREE = 9;

  localparam logic [DEF_N_FREE-1:0][DEF_MAP_W-1:0] DEF_FREE_OFF = {
    8'd12, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0
  };

  localparam logic [DEF_N_FREE-1:0][DEF_DW-1:0] DEF_FREE_IMPL = {
    32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF,
    32'h00FF00FF, 32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF
  };

  localparam logic [DEF_N_FREE-1:0][DEF_DW-1:0] DEF_FREE_RO = {
    32'h000000FF, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h0, 32'h0
  };

  localparam logic [DEF_N_FREE-1:0][DEF_DW-1:0] DEF_FREE_RST = {
    32'h000000C3, 32'h5A5A0001, 32'h0, 32'h0, 32'h11110000,
    32'h00AA0055, 32'h0, 32'h0BADF00D, 32'h0
  };

endpackage

// File: rtl/rfc_decode.sv
module rfc_decode
  import rfc_pkg::*;
#(
  parameter int MAP_W     = 8,
  parameter int N_FREE    = 9,
  parameter logic [N_FREE-1:0][MAP_W-1:0] FREE_OFF = '0,
  parameter int ARR_BASE  = 128,
  parameter int ARR_DEPTH = 128,
  parameter int AIDX_W    = 7
) (
  input  logic [MAP_W-1:0]  off,
  output rfc_src_e          src,
  output logic [N_FREE-1:0] free_sel,
  output logic [AIDX_W-1:0] arr_idx
);

  logic arr_in;

  // One comparator per freestanding register.
  for (genvar i = 0; i < N_FREE; i++) begin : g_cmp
    assign free_sel[i] = (off == FREE_OFF[i]);
  end

  // The array window is decoded relative to its base.
  always_comb begin
    arr_in  = (int'(off) >= ARR_BASE) && (int'(off) < ARR_BASE + ARR_DEPTH);
    arr_idx = AIDX_W'(off - MAP_W'(ARR_BASE));
  end

  always_comb begin
    if (|free_sel)   src = SRC_FREE;
    else if (arr_in) src = SRC_ARRAY;
    else             src = SRC_NONE;
  end

endmodule

// File: rtl/rfc_word.sv
module rfc_word #(
  parameter int            DW   = 32,
  parameter logic [DW-1:0] IMPL = '1,
  parameter logic [DW-1:0] RO   = '0,
  parameter logic [DW-1:0] RST  = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0]   wd,
  output logic [DW-1:0]   q
);

  localparam int BEW = DW / 8;
  localparam logic [DW-1:0] WR_BITS = IMPL & ~RO;

  logic [DW-1:0] lane;
  logic [DW-1:0] wmask;

  always_comb begin
    for (int k = 0; k < BEW; k++) lane[8*k +: 8] = {8{be[k]}};
    wmask = lane & WR_BITS;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= RST & IMPL;
    else if (we) q <= (q & ~wmask) | (wd & wmask);
  end

endmodule

// File: rtl/rfc_array.sv
module rfc_array #(
  parameter int            DW     = 32,
  parameter int            DEPTH  = 128,
  parameter int            AIDX_W = 7,
  parameter logic [DW-1:0] RST    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AIDX_W-1:0] widx,
  input  logic [DW/8-1:0]   be,
  input  logic [DW-1:0]     wd,
  input  logic [AIDX_W-1:0] ridx,
  output logic [DW-1:0]     rq
);

  localparam int BEW = DW / 8;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] lane;

  always_comb begin
    for (int k = 0; k < BEW; k++) lane[8*k +: 8] = {8{be[k]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= RST;
    end else if (we) begin
      mem[widx] <= (mem[widx] & ~lane) | (wd & lane);
    end
  end

  assign rq = (int'(ridx) < DEPTH) ? mem[ridx] : '0;

endmodule

// File: rtl/regfile_core.sv
module regfile_core
  import rfc_pkg::*;
#(
  parameter int DW        = DEF_DW,
  parameter int BUS_AW    = 16,
  parameter int MAP_W     = DEF_MAP_W,
  parameter int N_FREE    = DEF_N_FREE,
  parameter logic [N_FREE-1:0][MAP_W-1:0] FREE_OFF  = DEF_FREE_OFF,
  parameter logic [N_FREE-1:0][DW-1:0]    FREE_IMPL = DEF_FREE_IMPL,
  parameter logic [N_FREE-1:0][DW-1:0]    FREE_RO   = DEF_FREE_RO,
  parameter logic [N_FREE-1:0][DW-1:0]    FREE_RST  = DEF_FREE_RST,
  parameter int ARR_BASE  = 128,
  parameter int ARR_FRAME = 1,
  parameter int ARR_COUNT = 128,
  parameter logic [DW-1:0] ARR_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BUS_AW-1:0] wr_addr,
  input  logic [DW/8-1:0]   wr_be,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_ok,
  input  logic              rd_en,
  input  logic [BUS_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_ok
);

  localparam int BEW       = DW / 8;
  localparam int ARR_DEPTH = ARR_FRAME * ARR_COUNT;
  localparam int AIDX_W    = (ARR_DEPTH > 1) ? $clog2(ARR_DEPTH) : 1;

  logic [MAP_W-1:0]  w_off, r_off;
  rfc_src_e          w_src, r_src;
  logic [N_FREE-1:0] w_sel, r_sel;
  logic [AIDX_W-1:0] w_aidx, r_aidx;
  logic [N_FREE-1:0] can_write;

  logic [N_FREE-1:0][DW-1:0] free_q;
  logic [DW-1:0] arr_q;
  logic [DW-1:0] free_rd;

  logic unused_addr_hi;
  assign unused_addr_hi = ^{wr_addr[BUS_AW-1:MAP_W], rd_addr[BUS_AW-1:MAP_W]};

  // Only the low MAP_W address bits reach the decoders.
  assign w_off = wr_addr[MAP_W-1:0];
  assign r_off = rd_addr[MAP_W-1:0];

  rfc_decode #(
    .MAP_W(MAP_W), .N_FREE(N_FREE), .FREE_OFF(FREE_OFF),
    .ARR_BASE(ARR_BASE), .ARR_DEPTH(ARR_DEPTH), .AIDX_W(AIDX_W)
  ) wdec_i (
    .off(w_off), .src(w_src), .free_sel(w_sel), .arr_idx(w_aidx)
  );

  rfc_decode #(
    .MAP_W(MAP_W), .N_FREE(N_FREE), .FREE_OFF(FREE_OFF),
    .ARR_BASE(ARR_BASE), .ARR_DEPTH(ARR_DEPTH), .AIDX_W(AIDX_W)
  ) rdec_i (
    .off(r_off), .src(r_src), .free_sel(r_sel), .arr_idx(r_aidx)
  );

  for (genvar i = 0; i < N_FREE; i++) begin : g_reg
    assign can_write[i] = |(FREE_IMPL[i] & ~FREE_RO[i]);

    rfc_word #(
      .DW(DW), .IMPL(FREE_IMPL[i]), .RO(FREE_RO[i]), .RST(FREE_RST[i])
    ) word_i (
      .clk(clk), .rst(rst),
      .we(wr_en && w_sel[i] && can_write[i]),
      .be(wr_be), .wd(wr_data), .q(free_q[i])
    );
  end

  rfc_array #(
    .DW(DW), .DEPTH(ARR_DEPTH), .AIDX_W(AIDX_W), .RST(ARR_RST)
  ) arr_i (
    .clk(clk), .rst(rst),
    .we(wr_en && (w_src == SRC_ARRAY)),
    .widx(w_aidx), .be(wr_be), .wd(wr_data),
    .ridx(r_aidx), .rq(arr_q)
  );

  // Read mux for the freestanding registers: one-hot AND-OR.
  always_comb begin
    free_rd = '0;
    for (int i = 0; i < N_FREE; i++) begin
      if (r_sel[i]) free_rd = free_rd | free_q[i];
    end
  end

  assign wr_ok = wr_en && ((w_src == SRC_ARRAY) || (|(w_sel & can_write)));
  assign rd_ok = rd_en && (r_src != SRC_NONE);

  always_comb begin
    if (!rd_ok)                  rd_data = '0;
    else if (r_src == SRC_FREE)  rd_data = free_rd;
    else                         rd_data = arr_q;
  end

endmodule

// File: rtl/rfc_checker.sv
module rfc_checker #(
  parameter int DW     = 32,
  parameter int N_FREE = 9,
  parameter logic [N_FREE-1:0][DW-1:0] FREE_RO = '0
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en,
  input logic [DW/8-1:0]           wr_be,
  input logic                      wr_ok,
  input logic                      rd_en,
  input logic                      rd_ok,
  input logic [DW-1:0]             rd_data,
  input logic [N_FREE-1:0][DW-1:0] free_q
);

  p_wr_ok_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> wr_en);

  p_rd_ok_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    rd_ok |-> rd_en);

  p_rd_fail_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !rd_ok |-> (rd_data == '0));

  p_no_lane_no_change_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_be == '0)) |=> $stable(free_q));

  p_failed_write_inert_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_ok) |=> $stable(free_q));

  for (genvar i = 0; i < N_FREE; i++) begin : g_ro
    p_ro_bits_hold_r3: assert property (@(posedge clk) disable iff (rst)
      $stable(free_q[i] & FREE_RO[i]));
  end

endmodule

bind regfile_core rfc_checker #(
  .DW(DW), .N_FREE(N_FREE), .FREE_RO(FREE_RO)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_ok(wr_ok),
  .rd_en(rd_en), .rd_ok(rd_ok), .rd_data(rd_data), .free_q(free_q)
);

// File: tb/regfile_core_tb_top.sv
`timescale 1ns/1ps
module regfile_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ok;
  logic        rd_en = 1'b0;
  logic [15:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_ok;

  int total = 0;
  int bad = 0;
  logic [31:0] model [256];

  always #5 clk = ~clk;

  regfile_core dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .wr_ok(wr_ok), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ok(rd_ok)
  );

  function automatic logic [31:0] impl_of(int off);
    if (off >= 128 && off <= 255) return 32'hFFFFFFFF;
    case (off)
      0, 1, 4, 5, 6, 7: return 32'hFFFFFFFF;
      2, 12:            return 32'h0000FFFF;
      3:                return 32'h00FF00FF;
      default:          return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ro_of(int off);
    if (off == 7)  return 32'hFFFFFFFF;
    if (off == 12) return 32'h000000FF;
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int a = 0; a < 256; a++) model[a] = 32'h0;
    model[1]  = 32'h0BADF00D;
    model[3]  = 32'h00AA0055;
    model[4]  = 32'h11110000;
    model[7]  = 32'h5A5A0001;
    model[12] = 32'h000000C3;
  endtask

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive after the falling edge, compare before the rising
  // edge, then advance the model at the rising edge.
  task automatic step(input bit we, input logic [15:0] wa, input logic [31:0] wd,
                      input logic [3:0] be, input bit re, input logic [15:0] ra,
                      input string tag);
    int woff, roff;
    bit exp_wok, exp_rok;
    logic [31:0] exp_rd, wm, lane;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be;
    rd_en = re; rd_addr = ra;
    woff = int'(wa[7:0]);
    roff = int'(ra[7:0]);
    exp_wok = we && ((impl_of(woff) & ~ro_of(woff)) != 0);
    exp_rok = re && (impl_of(roff) != 0);
    exp_rd  = exp_rok ? model[roff] : 32'h0;
    #1;
    check(wr_ok == exp_wok, tag, "wr_ok", {31'b0, wr_ok}, {31'b0, exp_wok});
    check(rd_ok == exp_rok, tag, "rd_ok", {31'b0, rd_ok}, {31'b0, exp_rok});
    check(rd_data == exp_rd, tag, "rd_data", rd_data, exp_rd);
    @(posedge clk);
    if (exp_wok) begin
      lane = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      wm = lane & impl_of(woff) & ~ro_of(woff);
      model[woff] = (model[woff] & ~wm) | (wd & wm);
    end
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    step(1'b0, 16'h0, 32'h0, 4'h0, 1'b1, a, tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d,
                    input logic [3:0] be, input string tag);
    step(1'b1, a, d, be, 1'b0, 16'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int offs[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 12, 128, 200, 255};
    int o;
    model_reset();
    do_reset();

    // R1: reset values on every mapped register and array edges
    for (int i = 0; i < 12; i++) rd(16'(offs[i]), "R1");

    // R2: partial byte enables, then an all-zero enable
    wr(16'd0, 32'h11223344, 4'b0101, "R2");
    rd(16'd0, "R2");
    wr(16'd1, 32'hFFFFFFFF, 4'b1000, "R2");
    rd(16'd1, "R2");
    wr(16'd0, 32'hFFFFFFFF, 4'b0000, "R2");
    rd(16'd0, "R2");

    // R3: read-only bits
    wr(16'd12, 32'hFFFFFFFF, 4'hF, "R3");
    rd(16'd12, "R3");
    wr(16'd7, 32'h0, 4'hF, "R3");
    rd(16'd7, "R3");

    // R4: unimplemented bits read as zero
    wr(16'd2, 32'hFFFFFFFF, 4'hF, "R4");
    rd(16'd2, "R4");
    wr(16'd3, 32'hFFFFFFFF, 4'hF, "R4");
    rd(16'd3, "R4");

    // R5: write acknowledge on writable locations only
    wr(16'd6, 32'hCAFE0001, 4'hF, "R5");
    wr(16'd7, 32'hFFFFFFFF, 4'hF, "R5");
    rd(16'd6, "R5");

    // R7: array window edges and relative indexing
    wr(16'd128, 32'hA0A0A0A0, 4'hF, "R7");
    wr(16'd255, 32'h5F5F5F5F, 4'hF, "R7");
    wr(16'd127, 32'h12345678, 4'hF, "R7");
    rd(16'd128, "R7");
    rd(16'd255, "R7");
    rd(16'd129, "R7");

    // R8: high bus address bits are ignored
    wr(16'h0105, 32'h00C0FFEE, 4'hF, "R8");
    rd(16'h0005, "R8");
    rd(16'hFF05, "R8");

    // R9: read in the same cycle as a write sees the old value
    step(1'b1, 16'd4, 32'h99887766, 4'hF, 1'b1, 16'd4, "R9");
    rd(16'd4, "R9");

    // R10: unmapped holes on both ports
    wr(16'd8, 32'hFFFFFFFF, 4'hF, "R10");
    rd(16'd8, "R10");
    rd(16'd11, "R10");
    rd(16'd13, "R10");
    rd(16'd127, "R10");

    // R6: mixed traffic across mapped and unmapped offsets
    for (int n = 0; n < 400; n++) begin
      o = (n % 3 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 15));
      step(1'($urandom_range(0, 1)), {8'($urandom_range(0, 255)), 8'(o)},
           $urandom, 4'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)), 16'($urandom_range(0, 255)), "R6");
    end

    // R1: reset again after traffic
    do_reset();
    for (int i = 0; i < 12; i++) rd(16'(offs[i]), "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule